// File: doc/BRIEF.md
# Clock Interval Event Generator

This block sits beside a running time-of-day counter and raises a sticky interval event flag when a chosen periodic condition occurs. It receives the current hour, minute and second, plus a single-cycle update strobe that marks each counter advance. A 2-bit select picks one of four triggers. Two are change detectors: the minute field moved, or the hour field moved. Two are fixed daily matches: the time entered 00:00:00, or the time entered 12:00:00.

The flag holds until software pulses the clear input. An interrupt request follows the flag only while the enable input is high. The block samples the time only on the update strobe. Other movement on the inputs, including a change of the select, creates no event. The first strobe after reset only seeds the stored previous time.

Top module: `interval_event_gen`

## Requirements
- R1: After reset, `ev_flag` and `ev_irq` are 0.
- R2: With `ev_sel`=2'b00, an update strobe sets the flag when `minute` differs from the minute captured at the previous strobe.
- R3: With `ev_sel`=2'b01, an update strobe sets the flag when `hour` differs from the hour captured at the previous strobe.
- R4: With `ev_sel`=2'b10, an update strobe sets the flag when the time is 00:00:00 and the time captured at the previous strobe was not 00:00:00. It does not fire again while the time stays at 00:00:00.
- R5: With `ev_sel`=2'b11, an update strobe sets the flag when the time is 12:00:00 and the time captured at the previous strobe was not 12:00:00.
- R6: The first strobe after reset only captures the time and sets no flag. The captured time updates on every strobe, whatever the select.
- R7: Once set, the flag stays 1 until `ev_clr` is high in a cycle with no event; that clock edge clears it.
- R8: When an event and `ev_clr` fall on the same clock edge, the flag is set.
- R9: `ev_irq` is 1 exactly when `ev_flag` and `ev_ie` are both 1. `ev_ie` has no effect on the flag.
- R10: In cycles without `upd_tick`, the flag is never set. A change of `ev_sel` or of the time inputs alone creates no event.
- R11: An event sampled at a clock edge shows on `ev_flag` right after that edge. There is one register between the strobe and the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_tick | input | 1 | One-cycle strobe marking a time counter update |
| hour | input | 5 | Current hour, 0 to 23 |
| minute | input | 6 | Current minute, 0 to 59 |
| second | input | 6 | Current second, 0 to 59 |
| ev_sel | input | 2 | Trigger select: 00 minute change, 01 hour change, 10 midnight, 11 noon |
| ev_ie | input | 1 | Interrupt enable |
| ev_clr | input | 1 | Flag clear pulse |
| ev_flag | output | 1 | Sticky interval event flag |
| ev_irq | output | 1 | Interrupt request |

## Verification
An event seen on a strobe at clock edge k shows on `ev_flag` after edge k. A clear lands on the same edge. `ev_irq` follows the flag and `ev_ie` with no added delay. The bench drives every input at the falling edge and steps a behavioural model at the rising edge. It then compares both outputs at the next falling edge, so each expected value is due exactly one edge after its stimulus. Checks run on every cycle, including those with no strobe, to catch events that should not occur.

// File: rtl/ive_pkg.sv
package ive_pkg;

    typedef enum logic [1:0] {
        IVE_MIN      = 2'b00,
        IVE_HOUR     = 2'b01,
        IVE_MIDNIGHT = 2'b10,
        IVE_NOON     = 2'b11
    } ive_sel_e;

    typedef struct packed {
        logic primed;
        logic at_mid;
        logic at_noon;
    } ive_daily_t;

endpackage

// File: rtl/ive_field_delta.sv
module ive_field_delta #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_tick,
    input  logic [W-1:0] value,
    output logic         changed
);
    logic [W-1:0] prev_d, prev_q;
    logic         primed_d, primed_q;

    always_comb begin
        prev_d   = prev_q;
        primed_d = primed_q;
        changed  = 1'b0;
        if (upd_tick) begin
            changed  = primed_q && (value != prev_q);
            prev_d   = value;
            primed_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= prev_d;
            primed_q <= primed_d;
        end
    end
endmodule

// File: rtl/ive_daily_match.sv
module ive_daily_match
    import ive_pkg::*;
#(
    parameter int HOUR_W    = 5,
    parameter int MIN_W     = 6,
    parameter int SEC_W     = 6,
    parameter int NOON_HOUR = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_tick,
    input  logic [HOUR_W-1:0] hour,
    input  logic [MIN_W-1:0]  minute,
    input  logic [SEC_W-1:0]  second,
    output logic              enter_mid,
    output logic              enter_noon
);
    localparam logic [HOUR_W-1:0] NOON_H = HOUR_W'(NOON_HOUR);

    ive_daily_t st_d, st_q;
    logic       zero_ms, is_mid, is_noon;

    always_comb begin
        zero_ms    = (minute == '0) && (second == '0);
        is_mid     = zero_ms && (hour == '0);
        is_noon    = zero_ms && (hour == NOON_H);
        st_d       = st_q;
        enter_mid  = 1'b0;
        enter_noon = 1'b0;
        if (upd_tick) begin
            enter_mid  = st_q.primed && is_mid  && !st_q.at_mid;
            enter_noon = st_q.primed && is_noon && !st_q.at_noon;
            st_d.primed  = 1'b1;
            st_d.at_mid  = is_mid;
            st_d.at_noon = is_noon;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ive_flag.sv
module ive_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_ev)   flag_d = 1'b1;
        else if (clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/interval_event_gen.sv
module interval_event_gen
    import ive_pkg::*;
#(
    parameter int HOUR_W    = 5,
    parameter int MIN_W     = 6,
    parameter int SEC_W     = 6,
    parameter int NOON_HOUR = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_tick,
    input  logic [HOUR_W-1:0] hour,
    input  logic [MIN_W-1:0]  minute,
    input  logic [SEC_W-1:0]  second,
    input  logic [1:0]        ev_sel,
    input  logic              ev_ie,
    input  logic              ev_clr,
    output logic              ev_flag,
    output logic              ev_irq
);
    logic min_chg, hour_chg, enter_mid, enter_noon, sel_ev;

    ive_field_delta #(.W(MIN_W)) u_min (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .value(minute), .changed(min_chg)
    );

    ive_field_delta #(.W(HOUR_W)) u_hour (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .value(hour), .changed(hour_chg)
    );

    ive_daily_match #(
        .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .NOON_HOUR(NOON_HOUR)
    ) u_daily (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick),
        .hour(hour), .minute(minute), .second(second),
        .enter_mid(enter_mid), .enter_noon(enter_noon)
    );

    always_comb begin
        unique case (ive_sel_e'(ev_sel))
            IVE_MIN:      sel_ev = min_chg;
            IVE_HOUR:     sel_ev = hour_chg;
            IVE_MIDNIGHT: sel_ev = enter_mid;
            IVE_NOON:     sel_ev = enter_noon;
            default:      sel_ev = 1'b0;
        endcase
    end

    ive_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_ev(sel_ev), .clr(ev_clr), .flag(ev_flag)
    );

    assign ev_irq = ev_flag & ev_ie;
endmodule

// File: rtl/interval_event_gen_chk.sv
module interval_event_gen_chk #(
    parameter int HOUR_W    = 5,
    parameter int MIN_W     = 6,
    parameter int SEC_W     = 6,
    parameter int NOON_HOUR = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_tick,
    input logic [HOUR_W-1:0] hour,
    input logic [MIN_W-1:0]  minute,
    input logic [SEC_W-1:0]  second,
    input logic [1:0]        ev_sel,
    input logic              ev_ie,
    input logic              ev_clr,
    input logic              ev_flag,
    input logic              ev_irq
);
    localparam logic [HOUR_W-1:0] NOON_H = HOUR_W'(NOON_HOUR);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_flag && !ev_clr) |=> ev_flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_clr && !upd_tick) |=> !ev_flag);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_tick && !ev_flag) |=> !ev_flag);

    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ie |-> !ev_irq);

    p_irqflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_irq |-> ev_flag);

    p_midnight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && ev_sel == 2'b10 && !ev_flag &&
         (hour != '0 || minute != '0 || second != '0)) |=> !ev_flag);

    p_noon_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && ev_sel == 2'b11 && !ev_flag &&
         (hour != NOON_H || minute != '0 || second != '0)) |=> !ev_flag);
endmodule

bind interval_event_gen interval_event_gen_chk #(
    .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .NOON_HOUR(NOON_HOUR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .hour(hour), .minute(minute),
    .second(second), .ev_sel(ev_sel), .ev_ie(ev_ie), .ev_clr(ev_clr),
    .ev_flag(ev_flag), .ev_irq(ev_irq)
);

// File: tb/tb_interval_event_gen.sv
module tb_interval_event_gen;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_tick = 1'b0;
    logic [4:0] hour = '0;
    logic [5:0] minute = '0;
    logic [5:0] second = '0;
    logic [1:0] ev_sel = '0;
    logic       ev_ie = 1'b0;
    logic       ev_clr = 1'b0;
    logic       ev_flag, ev_irq;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    int  m_ph = 0, m_pm = 0, m_ps = 0;
    bit  m_primed = 0;
    bit  m_flag = 0;

    always #(PERIOD/2) clk = ~clk;

    interval_event_gen dut (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .hour(hour), .minute(minute),
        .second(second), .ev_sel(ev_sel), .ev_ie(ev_ie), .ev_clr(ev_clr),
        .ev_flag(ev_flag), .ev_irq(ev_irq)
    );

    task automatic compare(string req);
        checks++;
        if (ev_flag !== m_flag) begin
            bad++;
            $display("FAIL %s flag actual=%0b expected=%0b", req, ev_flag, m_flag);
        end
        checks++;
        if (ev_irq !== (m_flag && ev_ie)) begin
            bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", req, ev_irq, m_flag && ev_ie);
        end
    endtask

    task automatic step(bit t, int h, int m, int s, int sel, bit ie, bit clr, string req);
        bit ev;
        upd_tick = t; hour = 5'(h); minute = 6'(m); second = 6'(s);
        ev_sel = 2'(sel); ev_ie = ie; ev_clr = clr;
        @(posedge clk);
        ev = 0;
        if (t && m_primed) begin
            case (sel)
                0: ev = (m != m_pm);
                1: ev = (h != m_ph);
                2: ev = (h == 0 && m == 0 && s == 0) && !(m_ph == 0 && m_pm == 0 && m_ps == 0);
                default: ev = (h == 12 && m == 0 && s == 0) && !(m_ph == 12 && m_pm == 0 && m_ps == 0);
            endcase
        end
        if (ev) m_flag = 1;
        else if (clr) m_flag = 0;
        if (t) begin
            m_ph = h; m_pm = m; m_ps = s; m_primed = 1;
        end
        @(negedge clk);
        upd_tick = 0; ev_clr = 0;
        compare(req);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R6: first strobe at midnight only seeds
        step(1, 0, 0, 0, 2, 1, 0, "R6");
        step(1, 0, 0, 0, 2, 1, 0, "R4 stay");
        step(1, 0, 0, 1, 2, 1, 0, "R4 leave");
        step(1, 0, 0, 0, 2, 1, 0, "R4 enter R11 R9");
        step(0, 0, 0, 0, 2, 1, 0, "R7 hold");
        step(0, 3, 7, 9, 1, 0, 0, "R9 mask R7");
        step(0, 3, 7, 9, 1, 1, 1, "R7 clear");
        step(0, 3, 7, 9, 1, 1, 0, "R7 cleared");

        // R2 minute change
        step(1, 0, 0, 1, 0, 1, 0, "R2 no change");
        step(1, 0, 0, 2, 0, 1, 0, "R2 seconds only");
        step(1, 0, 1, 0, 0, 1, 0, "R2 minute moved");
        step(0, 0, 1, 0, 0, 1, 1, "R7 clear");
        step(1, 0, 1, 1, 0, 0, 0, "R2 same minute");

        // R3 hour change
        step(1, 0, 2, 0, 1, 1, 0, "R3 minute only");
        step(1, 1, 0, 0, 1, 1, 0, "R3 hour moved");
        step(1, 1, 0, 1, 1, 1, 1, "R7 clear on tick no event");

        // R10: select and time changes without strobe
        step(0, 5, 5, 5, 0, 1, 0, "R10 sel change");
        step(0, 0, 0, 0, 2, 1, 0, "R10 midnight no tick");
        step(0, 12, 0, 0, 3, 1, 0, "R10 noon no tick");
        // R6: capture updates under all selects; hour captured as 1 above
        step(1, 11, 59, 59, 2, 1, 0, "R6 capture");
        step(1, 11, 59, 59, 1, 1, 0, "R6 captured hour");

        // R5 noon
        step(1, 12, 0, 0, 3, 1, 0, "R5 enter noon");
        step(0, 12, 0, 0, 3, 1, 1, "R7 clear");
        step(1, 12, 0, 0, 3, 1, 0, "R5 stay noon");
        step(1, 0, 0, 0, 3, 1, 0, "R5 midnight not noon");

        // R8 set wins over clear
        step(1, 0, 1, 0, 0, 1, 1, "R8 set wins");
        step(1, 0, 1, 0, 0, 0, 1, "R8 then clear");
        step(1, 0, 2, 0, 0, 0, 1, "R8 set wins masked R9");
        step(0, 0, 2, 0, 0, 1, 0, "R9 unmasked");

        // reset again then first strobe
        rst_n = 1'b0;
        m_flag = 0; m_primed = 0;
        @(negedge clk);
        compare("R1 reapply");
        rst_n = 1'b1;
        step(1, 12, 0, 0, 3, 1, 0, "R6 first noon");
        step(1, 13, 0, 0, 1, 1, 0, "R3 after reseed");

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule